// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block sits between the execution core of a small 8-bit processor and its external memory bus. The core asks for one transfer at a time: an opcode fetch, a data read or a data write. Each request goes to one of two 64 KB memory spaces. The sequencer then drives the 16-bit address, the 8-bit write data, the read/write line, one enable line per memory space and an opcode-fetch marker. It holds a transfer for as long as the slow-device wait input stays high. Read data goes back to the core with a single-clock valid pulse.

Bus state advances only on machine-cycle ticks, one every `CLK_DIV` input clocks. With the default of 2, a 2.6 MHz oscillator gives a 1.3 MHz bus. Another master, such as a DMA engine or a second processor, can ask for the bus. The grant is given only at an instruction boundary, which the core signals with a one-clock end-of-instruction strobe. While the bus is granted, the output-enable signals for the address, data and control pins drop to zero, so the pads float, and no core request is accepted.

Top module: `xbus_sequencer`

## Requirements
- R1: After reset `bus_ack`, `mem_en_o`, `fetch_o`, `data_oe` and `rd_valid` are 0, while `rw_o`, `addr_oe` and `ctrl_oe` are 1.
- R2: Bus state changes only on a machine tick, one every `CLK_DIV` clocks. A transfer that sees no wait keeps its space enable high for exactly `CLK_DIV` clocks, and a request is accepted only on a tick edge.
- R3: During a transfer exactly one bit of `mem_en_o` is high, bit `req_space` (0 = main space, 1 = secondary space). When idle all bits are 0.
- R4: `rw_o` is 0 throughout a write transfer and 1 at all other times.
- R5: `fetch_o` is 1 only during a transfer whose `req_kind` is 0 (opcode fetch). Kind 1 is a data read, kind 2 is a data write, and kind 3 is treated as a data read.
- R6: `data_oe` is 1 and `data_o` equals the requested write byte during, and only during, a write transfer. The transfer address is held on `addr_o` for its whole length.
- R7: Each tick that sees `wait_in` high during a transfer lengthens it by one machine cycle (`CLK_DIV` clocks), and address and enables stay unchanged.
- R8: At the tick that ends a fetch or read, `data_i` is captured into `rd_data` and `rd_valid` pulses for one clock. A write produces no pulse.
- R9: `bus_ack` rises only on a tick while the sequencer is idle and an instruction boundary is pending. A boundary is set by `insn_end` and cleared when an opcode fetch is accepted.
- R10: While `bus_ack` is 1, `addr_oe`, `data_oe` and `ctrl_oe` are all 0.
- R11: After `bus_req` falls, `bus_ack` falls at the next tick, within `CLK_DIV` clocks.
- R12: While `bus_ack` is 1, `req_ready` stays 0 and no transfer starts.
- R13: Reset leaves a boundary pending, so a bus request is granted without any `insn_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Asynchronous reset, active high |
| req_valid | input | 1 | Core transfer request |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_space | input | SPACE_W (1) | Memory space select |
| req_addr | input | ADDR_W (16) | Transfer address |
| req_wdata | input | DATA_W (8) | Write byte |
| req_ready | output | 1 | Request accepted at this clock edge |
| rd_data | output | DATA_W (8) | Captured read byte |
| rd_valid | output | 1 | One-clock read completion pulse |
| insn_end | input | 1 | End-of-instruction strobe from core |
| wait_in | input | 1 | Slow-device wait, active high |
| bus_req | input | 1 | External bus request |
| bus_ack | output | 1 | Bus granted to external master |
| addr_o | output | ADDR_W (16) | Address bus value |
| addr_oe | output | 1 | Address pad output enable |
| data_o | output | DATA_W (8) | Write data bus value |
| data_i | input | DATA_W (8) | Read data bus value |
| data_oe | output | 1 | Data pad output enable |
| rw_o | output | 1 | 1 read, 0 write |
| mem_en_o | output | NUM_SPACE (2) | One enable per memory space |
| ctrl_oe | output | 1 | Output enable for rw and space enables |
| fetch_o | output | 1 | Opcode fetch marker |

## Verification
The assertions assume that `insn_end` is a single-clock strobe, that `wait_in` changes only between clock edges, and that the core holds its request fields stable until `req_ready` is seen. The grant check also assumes the external master keeps `bus_req` high until `bus_ack` answers. The bench drives every input at the falling clock edge and keeps each request steady until acceptance. It raises `bus_req` only while no transfer is being started, and it drops it only after the grant has been observed.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [1:0] {
      XK_FETCH = 2'd0,
      XK_READ  = 2'd1,
      XK_WRITE = 2'd2,
      XK_READX = 2'd3
   } xfer_kind_e;

   typedef enum logic {
      SQ_IDLE   = 1'b0,
      SQ_ACCESS = 1'b1
   } seq_state_e;

   function automatic logic kind_is_write(input xfer_kind_e k);
      return k == XK_WRITE;
   endfunction

   function automatic logic kind_is_fetch(input xfer_kind_e k);
      return k == XK_FETCH;
   endfunction

endpackage

// File: rtl/xbus_phase_gen.sv
module xbus_phase_gen #(
   parameter int CLK_DIV = 2
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

   initial begin
      if (CLK_DIV < 1) $error("xbus_phase_gen: CLK_DIV must be at least 1");
   end

   generate
      if (CLK_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or posedge rst) begin
            if (rst)
               cnt_q <= '0;
            else if (cnt_q == LAST)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/xbus_grant_ctl.sv
module xbus_grant_ctl (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic bus_req,
   input  logic insn_end,
   input  logic fetch_accept,
   input  logic seq_idle,
   output logic grant_now,
   output logic bus_ack,
   output logic at_boundary
);
   logic ack_q;
   logic bnd_q;

   assign grant_now = tick && !ack_q && bus_req && bnd_q && seq_idle;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         ack_q <= 1'b0;
      else if (grant_now)
         ack_q <= 1'b1;
      else if (tick && ack_q && !bus_req)
         ack_q <= 1'b0;
   end

   // A fetch starting in the same clock as the strobe opens a new instruction.
   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         bnd_q <= 1'b1;
      else if (fetch_accept)
         bnd_q <= 1'b0;
      else if (insn_end)
         bnd_q <= 1'b1;
   end

   assign bus_ack     = ack_q;
   assign at_boundary = bnd_q;

endmodule

// File: rtl/xbus_cycle_fsm.sv
module xbus_cycle_fsm
   import xbus_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int SPACE_W = 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick,
   input  logic               block,
   input  logic               req_valid,
   input  xfer_kind_e         req_kind,
   input  logic [SPACE_W-1:0] req_space,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic               wait_in,
   input  logic [DATA_W-1:0]  data_i,
   output logic               req_ready,
   output logic               fetch_accept,
   output logic               seq_idle,
   output logic               active,
   output xfer_kind_e         cur_kind,
   output logic [SPACE_W-1:0] cur_space,
   output logic [ADDR_W-1:0]  cur_addr,
   output logic [DATA_W-1:0]  cur_wdata,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rd_valid
);
   seq_state_e state_q;
   seq_state_e state_d;
   logic       accept;
   logic       finish;

   assign seq_idle     = (state_q == SQ_IDLE);
   assign req_ready    = tick && seq_idle && !block;
   assign accept       = req_ready && req_valid;
   assign fetch_accept = accept && kind_is_fetch(req_kind);
   assign finish       = tick && (state_q == SQ_ACCESS) && !wait_in;
   assign active       = (state_q == SQ_ACCESS);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE:   if (accept) state_d = SQ_ACCESS;
         SQ_ACCESS: if (finish) state_d = SQ_IDLE;
         default:   state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         state_q <= SQ_IDLE;
      else
         state_q <= state_d;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cur_kind  <= XK_READ;
         cur_space <= '0;
         cur_addr  <= '0;
         cur_wdata <= '0;
      end else if (accept) begin
         cur_kind  <= req_kind;
         cur_space <= req_space;
         cur_addr  <= req_addr;
         cur_wdata <= req_wdata;
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= finish && !kind_is_write(cur_kind);
         if (finish && !kind_is_write(cur_kind))
            rd_data <= data_i;
      end
   end

endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
   import xbus_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int NUM_SPACE = 2,
   parameter int CLK_DIV   = 2,
   localparam int SPACE_W  = (NUM_SPACE > 1) ? $clog2(NUM_SPACE) : 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 req_valid,
   input  logic [1:0]           req_kind,
   input  logic [SPACE_W-1:0]   req_space,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 req_ready,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 rd_valid,
   input  logic                 insn_end,
   input  logic                 wait_in,
   input  logic                 bus_req,
   output logic                 bus_ack,
   output logic [ADDR_W-1:0]    addr_o,
   output logic                 addr_oe,
   output logic [DATA_W-1:0]    data_o,
   input  logic [DATA_W-1:0]    data_i,
   output logic                 data_oe,
   output logic                 rw_o,
   output logic [NUM_SPACE-1:0] mem_en_o,
   output logic                 ctrl_oe,
   output logic                 fetch_o
);
   initial begin
      if (ADDR_W < 1)    $error("xbus_sequencer: ADDR_W must be positive");
      if (DATA_W < 1)    $error("xbus_sequencer: DATA_W must be positive");
      if (NUM_SPACE < 2) $error("xbus_sequencer: NUM_SPACE must be at least 2");
      if (CLK_DIV < 1)   $error("xbus_sequencer: CLK_DIV must be at least 1");
   end

   logic               tick;
   logic               grant_now;
   logic               at_boundary;
   logic               fetch_accept;
   logic               seq_idle;
   logic               active;
   xfer_kind_e         cur_kind;
   logic [SPACE_W-1:0] cur_space;
   logic [ADDR_W-1:0]  cur_addr;
   logic [DATA_W-1:0]  cur_wdata;

   xbus_phase_gen #(.CLK_DIV(CLK_DIV)) u_phase (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   xbus_grant_ctl u_grant (
      .clk          (clk),
      .rst          (rst),
      .tick         (tick),
      .bus_req      (bus_req),
      .insn_end     (insn_end),
      .fetch_accept (fetch_accept),
      .seq_idle     (seq_idle),
      .grant_now    (grant_now),
      .bus_ack      (bus_ack),
      .at_boundary  (at_boundary)
   );

   xbus_cycle_fsm #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .SPACE_W (SPACE_W)
   ) u_fsm (
      .clk          (clk),
      .rst          (rst),
      .tick         (tick),
      .block        (bus_ack || grant_now),
      .req_valid    (req_valid),
      .req_kind     (xfer_kind_e'(req_kind)),
      .req_space    (req_space),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .wait_in      (wait_in),
      .data_i       (data_i),
      .req_ready    (req_ready),
      .fetch_accept (fetch_accept),
      .seq_idle     (seq_idle),
      .active       (active),
      .cur_kind     (cur_kind),
      .cur_space    (cur_space),
      .cur_addr     (cur_addr),
      .cur_wdata    (cur_wdata),
      .rd_data      (rd_data),
      .rd_valid     (rd_valid)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SPACE; gi++) begin : g_space_en
         assign mem_en_o[gi] = active && (cur_space == SPACE_W'(gi));
      end
   endgenerate

   assign addr_o  = cur_addr;
   assign data_o  = cur_wdata;
   assign rw_o    = !(active && kind_is_write(cur_kind));
   assign fetch_o = active && kind_is_fetch(cur_kind);
   assign data_oe = active && kind_is_write(cur_kind) && !bus_ack;
   assign addr_oe = !bus_ack;
   assign ctrl_oe = !bus_ack;

endmodule

// File: rtl/xbus_sequencer_chk.sv
module xbus_sequencer_chk #(
   parameter int ADDR_W    = 16,
   parameter int NUM_SPACE = 2
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 tick,
   input logic                 at_boundary,
   input logic                 bus_req,
   input logic                 bus_ack,
   input logic                 addr_oe,
   input logic                 data_oe,
   input logic                 ctrl_oe,
   input logic [NUM_SPACE-1:0] mem_en_o,
   input logic                 rw_o,
   input logic                 fetch_o,
   input logic                 wait_in,
   input logic [ADDR_W-1:0]    addr_o,
   input logic                 req_ready,
   input logic                 rd_valid
);
   p_one_space_r3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(mem_en_o));

   p_write_drive_r6: assert property (@(posedge clk) disable iff (rst)
      data_oe |-> (!rw_o && ctrl_oe && mem_en_o != '0));

   p_fetch_is_read_r5: assert property (@(posedge clk) disable iff (rst)
      fetch_o |-> (rw_o && mem_en_o != '0));

   p_wait_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (mem_en_o != '0 && wait_in) |=> (mem_en_o == $past(mem_en_o) && addr_o == $past(addr_o)));

   p_rd_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      rd_valid |=> !rd_valid);

   p_grant_boundary_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_ack) |-> ($past(at_boundary) && $past(mem_en_o) == '0));

   p_float_r10: assert property (@(posedge clk) disable iff (rst)
      bus_ack |-> (!addr_oe && !data_oe && !ctrl_oe));

   p_release_r11: assert property (@(posedge clk) disable iff (rst)
      (bus_ack && !bus_req && tick) |=> !bus_ack);

   p_stall_r12: assert property (@(posedge clk) disable iff (rst)
      bus_ack |-> (!req_ready && mem_en_o == '0));

endmodule

bind xbus_sequencer xbus_sequencer_chk #(
   .ADDR_W    (ADDR_W),
   .NUM_SPACE (NUM_SPACE)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .tick        (tick),
   .at_boundary (at_boundary),
   .bus_req     (bus_req),
   .bus_ack     (bus_ack),
   .addr_oe     (addr_oe),
   .data_oe     (data_oe),
   .ctrl_oe     (ctrl_oe),
   .mem_en_o    (mem_en_o),
   .rw_o        (rw_o),
   .fetch_o     (fetch_o),
   .wait_in     (wait_in),
   .addr_o      (addr_o),
   .req_ready   (req_ready),
   .rd_valid    (rd_valid)
);

// File: tb/xbus_sequencer_test.sv
module xbus_sequencer_test;
   localparam int AW  = 16;
   localparam int DW  = 8;
   localparam int NS  = 2;
   localparam int DIV = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = 2'd0;
   logic [0:0]    req_space = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic          insn_end = 1'b0;
   logic          wait_in = 1'b0;
   logic          bus_req = 1'b0;
   logic          bus_ack;
   logic [AW-1:0] addr_o;
   logic          addr_oe;
   logic [DW-1:0] data_o;
   logic [DW-1:0] data_i;
   logic          data_oe;
   logic          rw_o;
   logic [NS-1:0] mem_en_o;
   logic          ctrl_oe;
   logic          fetch_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   // Memory model: byte value depends on address and selected space.
   assign data_i = addr_o[7:0] ^ addr_o[15:8] ^ (mem_en_o[1] ? 8'hA5 : 8'h00);

   xbus_sequencer #(.ADDR_W(AW), .DATA_W(DW), .NUM_SPACE(NS), .CLK_DIV(DIV)) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
      .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
      .insn_end(insn_end), .wait_in(wait_in), .bus_req(bus_req), .bus_ack(bus_ack),
      .addr_o(addr_o), .addr_oe(addr_oe), .data_o(data_o), .data_i(data_i),
      .data_oe(data_oe), .rw_o(rw_o), .mem_en_o(mem_en_o), .ctrl_oe(ctrl_oe),
      .fetch_o(fetch_o)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // One transfer: kind, space, address, write byte, number of waited ticks.
   task automatic transfer(input int kind, input int sp, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input int waits);
      int  len;
      bit  bad_en, bad_rw, bad_fe, bad_wd, bad_ad;
      bit  is_wr;
      logic [DW-1:0] exp_rd;
      is_wr  = (kind == 2);
      exp_rd = a[7:0] ^ a[15:8] ^ (sp == 1 ? 8'hA5 : 8'h00);
      req_valid = 1'b1; req_kind = 2'(kind); req_space = 1'(sp);
      req_addr = a; req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      len = 0; bad_en = 0; bad_rw = 0; bad_fe = 0; bad_wd = 0; bad_ad = 0;
      while (mem_en_o != '0 && len < 64) begin
         wait_in = (len < waits * DIV);
         if (mem_en_o != NS'(1 << sp)) bad_en = 1;
         if (rw_o != !is_wr) bad_rw = 1;
         if (fetch_o != (kind == 0)) bad_fe = 1;
         if (data_oe != is_wr || (is_wr && data_o != wd)) bad_wd = 1;
         if (addr_o != a) bad_ad = 1;
         len++;
         @(negedge clk);
      end
      wait_in = 1'b0;
      check(len == (waits + 1) * DIV, waits == 0 ? "R2 transfer length" : "R7 waited length",
            32'(len), 32'((waits + 1) * DIV));
      check(!bad_en, "R3 space enable", 32'(mem_en_o), 32'(1 << sp));
      check(!bad_rw, "R4 rw level", 32'(bad_rw), 0);
      check(!bad_fe, "R5 fetch marker", 32'(bad_fe), 0);
      check(!bad_wd && !bad_ad, "R6 write data/address", 32'(data_o), 32'(wd));
      if (is_wr)
         check(!rd_valid, "R8 no read pulse on write", 32'(rd_valid), 0);
      else
         check(rd_valid && rd_data == exp_rd, "R8 read capture", 32'(rd_data), 32'(exp_rd));
      @(negedge clk);
      check(!rd_valid, "R8 pulse one clock", 32'(rd_valid), 0);
      check(mem_en_o == '0 && rw_o && !fetch_o, "R3 idle enables", 32'(mem_en_o), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(!bus_ack && mem_en_o == '0 && !fetch_o && !data_oe && !rd_valid,
            "R1 reset outputs low", {bus_ack, mem_en_o, fetch_o, data_oe, rd_valid}, 0);
      check(rw_o && addr_oe && ctrl_oe, "R1 reset outputs high", {rw_o, addr_oe, ctrl_oe}, 3'b111);

      // R13: grant straight after reset, with no end-of-instruction strobe.
      bus_req = 1'b1;
      cnt = 0;
      while (!bus_ack && cnt < 4 * DIV) begin @(negedge clk); cnt++; end
      check(bus_ack, "R13 grant after reset", 32'(bus_ack), 1);
      check(!addr_oe && !data_oe && !ctrl_oe, "R10 pads floated", {addr_oe, data_oe, ctrl_oe}, 0);
      // R12: a pending request is stalled while granted.
      req_valid = 1'b1; req_kind = 2'd0; req_addr = 16'h0100;
      cnt = 0;
      for (int i = 0; i < 3 * DIV; i++) begin
         if (req_ready || mem_en_o != '0) cnt++;
         @(negedge clk);
      end
      check(cnt == 0, "R12 stalled while granted", 32'(cnt), 0);
      req_valid = 1'b0;
      // R11: release within one machine cycle.
      bus_req = 1'b0;
      cnt = 0;
      while (bus_ack && cnt < 4 * DIV) begin @(negedge clk); cnt++; end
      check(!bus_ack && cnt >= 1 && cnt <= DIV, "R11 release delay", 32'(cnt), 32'(DIV));
      check(addr_oe && ctrl_oe, "R10 pads driven after release", {addr_oe, ctrl_oe}, 2'b11);

      // Near-exhaustive sweep over kind, space and wait count.
      for (int k = 0; k < 4; k++)
         for (int s = 0; s < NS; s++)
            for (int w = 0; w < 3; w++)
               transfer(k, s, 16'(16'h1357 * (k * 7 + s * 3 + w + 1)), 8'(8'h3C + k * 16 + s * 5 + w), w);

      // R9: mid-instruction request waits for the boundary strobe.
      transfer(0, 0, 16'h8000, 8'h00, 0);
      bus_req = 1'b1;
      cnt = 0;
      for (int i = 0; i < 5 * DIV; i++) begin
         if (bus_ack) cnt++;
         @(negedge clk);
      end
      check(cnt == 0, "R9 no grant inside instruction", 32'(cnt), 0);
      insn_end = 1'b1;
      @(negedge clk);
      insn_end = 1'b0;
      cnt = 0;
      while (!bus_ack && cnt < 4 * DIV) begin @(negedge clk); cnt++; end
      check(bus_ack && cnt <= DIV, "R9 grant at boundary", 32'(cnt), 32'(DIV));
      check(!addr_oe && !data_oe && !ctrl_oe, "R10 pads floated at boundary grant",
            {addr_oe, data_oe, ctrl_oe}, 0);
      bus_req = 1'b0;
      repeat (2 * DIV) @(negedge clk);
      check(!bus_ack, "R11 released", 32'(bus_ack), 0);

      // Transfers resume after release.
      transfer(2, 1, 16'hFFFF, 8'hFF, 1);
      transfer(1, 1, 16'h0000, 8'h00, 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule